// File: doc/BRIEF.md
# Outgoing Packet Framer with DMA Payload Feed

This block assembles outgoing network packets on a 64-bit datapath. Host software fills a small set of write-only send registers: a routing word that the network routers use to reach the target node, a header word that tells the receiving interface where to place the data and what to do once it arrives, and a payload length in words. A write to the trigger address starts the send sequencer.

The sequencer emits the routing word, then the header word, then exactly the programmed number of payload words. It pulls the payload words from a streaming DMA read port. Every output word passes through a single output register under valid/ready flow control. The final word of each packet carries an end-of-data flag. A busy output covers the whole packet. Completion and misuse are reported as sticky status bits, and a write to a clear address resets them.

Top module: `pkt_send_framer`

## Requirements
- R1: After reset, busy, net_valid, dma_ready, pkt_done and trig_err are all 0.
- R2: The first word of every packet equals the routing register, which is written at address 0. This word has net_eod at 0.
- R3: The second word equals the header register, which is written at address 1. Its layout is version [63:60], action [59:58] (bit 59 selects the destination address, bit 58 requests a receiver interrupt), reserved [57:48] and physical destination address [47:0]. The header register resets to zero, so both action bits are off unless software sets them.
- R4: Payload words follow the header, word for word and in the order the DMA port delivers them. The count equals the length register, which is written at address 2 from bits [15:0]. The block accepts exactly that many DMA words.
- R5: net_eod is 1 on the last word of a packet and 0 on every other word.
- R6: With a length of 0, the packet is only the routing word and the header word, and net_eod is set on the header word.
- R7: While net_valid is 1 and net_ready is 0, the output word and its end-of-data flag hold steady. A word is consumed only on a cycle with both signals high.
- R8: A write to address 3 while idle starts a packet and clears pkt_done. busy stays 1 until the last word is accepted. pkt_done is then set and stays set. Writing bit 0 to address 4 clears pkt_done.
- R9: A write to address 3 while busy does not disturb the packet in progress, and it sets trig_err on the next cycle. trig_err stays set until bit 1 is written to address 4.
- R10: While busy, writes to addresses 0, 1 and 2 are ignored. The next packet sent without rewriting them uses the earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Send register write strobe |
| reg_wr_addr | input | 3 | Register address (0 route, 1 header, 2 length, 3 trigger, 4 status clear) |
| reg_wr_data | input | 64 | Register write data |
| dma_valid | input | 1 | DMA payload word available |
| dma_data | input | 64 | DMA payload word |
| dma_ready | output | 1 | Framer takes the DMA word this cycle |
| net_valid | output | 1 | Output word valid |
| net_data | output | 64 | Output word |
| net_eod | output | 1 | End-of-data flag on the output word |
| net_ready | input | 1 | Network accepts the output word |
| busy | output | 1 | Packet in progress |
| pkt_done | output | 1 | Sticky: last packet completed |
| trig_err | output | 1 | Sticky: trigger written while busy |

## Verification
The hardest case to reach is the collision between the network stalling and the DMA port starving in the middle of a packet. A stalled output word must stay put, and the payload counter must still stop exactly at the programmed length. The bench walks a table of packets that combine periodic ready patterns with gapped DMA valid patterns, and it checks every accepted word, its flag and every stalled cycle. Misuse during a packet is reached by injecting register writes a few cycles after the trigger, while the sequencer is known to be mid-packet.

// File: rtl/framer_pkg.sv
package framer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_HDR,
        ST_PAY,
        ST_FIN
    } fr_state_e;

    localparam logic [2:0] A_ROUTE = 3'd0;
    localparam logic [2:0] A_HDR   = 3'd1;
    localparam logic [2:0] A_LEN   = 3'd2;
    localparam logic [2:0] A_TRIG  = 3'd3;
    localparam logic [2:0] A_CLR   = 3'd4;
endpackage

// File: rtl/framer_regs.sv
module framer_regs
    import framer_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              done_evt,
    output logic              start,
    output logic [DATA_W-1:0] route_q,
    output logic [DATA_W-1:0] hdr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              done_q,
    output logic              err_q
);
    typedef struct packed {
        logic [DATA_W-1:0] route;
        logic [DATA_W-1:0] hdr;
        logic [LEN_W-1:0]  len;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                A_ROUTE: if (!busy) r_d.route = wr_data;
                A_HDR:   if (!busy) r_d.hdr = wr_data;
                A_LEN:   if (!busy) r_d.len = wr_data[LEN_W-1:0];
                A_TRIG: begin
                    if (busy) begin
                        r_d.err = 1'b1;
                    end else begin
                        start     = 1'b1;
                        r_d.done  = 1'b0;
                    end
                end
                A_CLR: begin
                    if (wr_data[0]) r_d.done = 1'b0;
                    if (wr_data[1]) r_d.err  = 1'b0;
                end
                default: ;
            endcase
        end
        if (done_evt) r_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign route_q = r_q.route;
    assign hdr_q   = r_q.hdr;
    assign len_q   = r_q.len;
    assign done_q  = r_q.done;
    assign err_q   = r_q.err;
endmodule

// File: rtl/framer_seq.sv
module framer_seq
    import framer_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] route,
    input  logic [DATA_W-1:0] hdr,
    input  logic [LEN_W-1:0]  len,
    input  logic              dma_valid,
    input  logic [DATA_W-1:0] dma_data,
    output logic              dma_ready,
    input  logic              net_ready,
    output logic              net_valid,
    output logic [DATA_W-1:0] net_data,
    output logic              net_eod,
    output logic              busy,
    output logic              done_evt
);
    typedef struct packed {
        fr_state_e         st;
        logic [LEN_W-1:0]  cnt;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              eod;
    } seq_t;

    seq_t s_d, s_q;
    logic can_load;
    logic last_pay;

    assign can_load = !s_q.vld || net_ready;
    assign last_pay = (LEN_W'(s_q.cnt + 1'b1) == len);

    always_comb begin
        s_d       = s_q;
        dma_ready = 1'b0;
        done_evt  = 1'b0;
        if (can_load) s_d.vld = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st  = ST_ROUTE;
                    s_d.cnt = '0;
                end
            end
            ST_ROUTE: begin
                if (can_load) begin
                    s_d.vld  = 1'b1;
                    s_d.data = route;
                    s_d.eod  = 1'b0;
                    s_d.st   = ST_HDR;
                end
            end
            ST_HDR: begin
                if (can_load) begin
                    s_d.vld  = 1'b1;
                    s_d.data = hdr;
                    s_d.eod  = (len == '0);
                    s_d.st   = (len == '0) ? ST_FIN : ST_PAY;
                end
            end
            ST_PAY: begin
                dma_ready = can_load;
                if (can_load && dma_valid) begin
                    s_d.vld  = 1'b1;
                    s_d.data = dma_data;
                    s_d.eod  = last_pay;
                    s_d.cnt  = LEN_W'(s_q.cnt + 1'b1);
                    if (last_pay) s_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                if (can_load) begin
                    s_d.st   = ST_IDLE;
                    done_evt = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign net_valid = s_q.vld;
    assign net_data  = s_q.data;
    assign net_eod   = s_q.eod & s_q.vld;
    assign busy      = (s_q.st != ST_IDLE);
endmodule

// File: rtl/pkt_send_framer.sv
module pkt_send_framer #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              dma_valid,
    input  logic [DATA_W-1:0] dma_data,
    output logic              dma_ready,
    output logic              net_valid,
    output logic [DATA_W-1:0] net_data,
    output logic              net_eod,
    input  logic              net_ready,
    output logic              busy,
    output logic              pkt_done,
    output logic              trig_err
);
    logic              start;
    logic              done_evt;
    logic [DATA_W-1:0] route_w;
    logic [DATA_W-1:0] hdr_w;
    logic [LEN_W-1:0]  len_w;

    framer_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .busy     (busy),
        .done_evt (done_evt),
        .start    (start),
        .route_q  (route_w),
        .hdr_q    (hdr_w),
        .len_q    (len_w),
        .done_q   (pkt_done),
        .err_q    (trig_err)
    );

    framer_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .route     (route_w),
        .hdr       (hdr_w),
        .len       (len_w),
        .dma_valid (dma_valid),
        .dma_data  (dma_data),
        .dma_ready (dma_ready),
        .net_ready (net_ready),
        .net_valid (net_valid),
        .net_data  (net_data),
        .net_eod   (net_eod),
        .busy      (busy),
        .done_evt  (done_evt)
    );
endmodule

// File: rtl/framer_chk.sv
module framer_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [2:0]        reg_wr_addr,
    input logic              dma_ready,
    input logic              net_valid,
    input logic [DATA_W-1:0] net_data,
    input logic              net_eod,
    input logic              net_ready,
    input logic              busy,
    input logic              pkt_done,
    input logic              trig_err
);
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_valid && !net_ready |=> net_valid && $stable(net_data) && $stable(net_eod));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !net_valid && !dma_ready);

    // R8
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pkt_done);

    // R9
    busy_trig_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr_en && reg_wr_addr == 3'd3 |=> trig_err && busy);
endmodule

bind pkt_send_framer framer_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .dma_ready   (dma_ready),
    .net_valid   (net_valid),
    .net_data    (net_data),
    .net_eod     (net_eod),
    .net_ready   (net_ready),
    .busy        (busy),
    .pkt_done    (pkt_done),
    .trig_err    (trig_err)
);

// File: tb/test_pkt_send_framer.sv
module test_pkt_send_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [63:0] reg_wr_data = '0;
    logic        dma_valid = 1'b0;
    logic [63:0] dma_data = '0;
    logic        dma_ready;
    logic        net_valid;
    logic [63:0] net_data;
    logic        net_eod;
    logic        net_ready = 1'b0;
    logic        busy;
    logic        pkt_done;
    logic        trig_err;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_hdr;

    always #10 clk = ~clk;

    pkt_send_framer i_pkt_send_framer (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .dma_valid(dma_valid), .dma_data(dma_data),
        .dma_ready(dma_ready), .net_valid(net_valid), .net_data(net_data),
        .net_eod(net_eod), .net_ready(net_ready), .busy(busy),
        .pkt_done(pkt_done), .trig_err(trig_err)
    );

    // {len[15:0], ready mode[1:0], dma mode[1:0], seed[7:0]}
    localparam logic [27:0] VEC [7] = '{
        {16'd5, 2'd0, 2'd0, 8'h21},
        {16'd0, 2'd0, 2'd0, 8'h22},
        {16'd1, 2'd1, 2'd0, 8'h23},
        {16'd4, 2'd2, 2'd1, 8'h24},
        {16'd0, 2'd1, 2'd1, 8'h25},
        {16'd8, 2'd1, 2'd2, 8'h26},
        {16'd3, 2'd2, 2'd2, 8'h27}
    };

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic rdy(input logic [1:0] m, input int c);
        if (m == 2'd1) return c[0];
        if (m == 2'd2) return (c % 3) != 0;
        return 1'b1;
    endfunction

    function automatic logic dv(input logic [1:0] m, input int c);
        if (m == 2'd1) return c[0] == 1'b0;
        if (m == 2'd2) return (c % 4) == 3;
        return 1'b1;
    endfunction

    function automatic logic [63:0] pat(input logic [7:0] s, input int i);
        return {s, 24'h5A5A00, 32'(i)};
    endfunction

    // poke: 0 none, 1 trigger while busy, 2 route write while busy
    task automatic run_pkt(input logic [63:0] rt, input int len, input logic [1:0] rm,
                           input logic [1:0] dm, input logic [7:0] seed, input int poke);
        int got = 0;
        int di = 0;
        int cyc = 0;
        logic hold_pend = 1'b0;
        logic [63:0] hold_d = '0;
        logic hold_e = 1'b0;
        logic [63:0] expw;
        reg_write(3'd3, 64'd0);
        #1;
        check(busy == 1'b1, "R8 busy after trigger", 64'(busy), 64'd1);
        check(pkt_done == 1'b0, "R8 done cleared by trigger", 64'(pkt_done), 64'd0);
        while (got < len + 2 && cyc < 3000) begin
            @(negedge clk);
            net_ready = rdy(rm, cyc);
            dma_valid = dv(dm, cyc);
            dma_data  = pat(seed, di);
            if (poke != 0 && cyc == 2) begin
                reg_wr_en = 1'b1;
                reg_wr_addr = (poke == 1) ? 3'd3 : 3'd0;
                reg_wr_data = 64'hDEAD_BEEF_0000_0001;
            end else begin
                reg_wr_en = 1'b0;
            end
            #1;
            if (hold_pend)
                check(net_valid && net_data == hold_d && net_eod == hold_e,
                      "R7 stalled word held", net_data, hold_d);
            hold_pend = net_valid && !net_ready;
            hold_d = net_data;
            hold_e = net_eod;
            if (net_valid && net_ready) begin
                if (got == 0) begin
                    expw = rt;
                    check(net_data == expw, "R2 routing word", net_data, expw);
                end else if (got == 1) begin
                    expw = exp_hdr;
                    check(net_data == expw, "R3 header word", net_data, expw);
                end else begin
                    expw = pat(seed, got - 2);
                    check(net_data == expw, "R4 payload word", net_data, expw);
                end
                if (len == 0)
                    check(net_eod == (got == 1), "R6 eod on header", 64'(net_eod), 64'(got == 1));
                else
                    check(net_eod == (got == len + 1), "R5 eod placement", 64'(net_eod), 64'(got == len + 1));
                got++;
            end
            if (dma_valid && dma_ready) di++;
            cyc++;
        end
        reg_wr_en = 1'b0;
        @(negedge clk);
        net_ready = 1'b0;
        dma_valid = 1'b0;
        #1;
        check(got == len + 2, "R4 word count", 64'(got), 64'(len + 2));
        check(di == len, "R4 dma words taken", 64'(di), 64'(len));
        check(!busy && !net_valid, "R8 idle after packet", 64'(busy), 64'd0);
        check(pkt_done == 1'b1, "R8 done set", 64'(pkt_done), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !net_valid && !dma_ready && !pkt_done && !trig_err,
              "R1 reset state", {59'd0, busy, net_valid, dma_ready, pkt_done, trig_err}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: header register untouched since reset -> all fields zero, action bits off
        exp_hdr = 64'd0;
        reg_write(3'd0, 64'h0000_0001_0002_0003);
        reg_write(3'd2, 64'd2);
        run_pkt(64'h0000_0001_0002_0003, 2, 2'd0, 2'd0, 8'h11, 0);

        for (int k = 0; k < 7; k++) begin
            logic [15:0] len;
            logic [1:0] rm, dm;
            logic [7:0] sd;
            logic [63:0] rt;
            {len, rm, dm, sd} = VEC[k];
            rt = {48'h0, 8'hC0, sd};
            exp_hdr = {4'h2, sd[1:0], 10'h0, 40'h12_3400_0000, sd};
            reg_write(3'd0, rt);
            reg_write(3'd1, exp_hdr);
            reg_write(3'd2, 64'(len));
            run_pkt(rt, int'(len), rm, dm, sd, 0);
        end

        // R9: trigger while busy
        exp_hdr = {4'h3, 2'b11, 10'h0, 48'hABCD_0000_1000};
        reg_write(3'd0, 64'h0000_00AA_0000_0055);
        reg_write(3'd1, exp_hdr);
        reg_write(3'd2, 64'd6);
        run_pkt(64'h0000_00AA_0000_0055, 6, 2'd1, 2'd0, 8'h31, 1);
        check(trig_err == 1'b1, "R9 error sticky", 64'(trig_err), 64'd1);
        reg_write(3'd4, 64'd2);
        #1;
        check(trig_err == 1'b0, "R9 error cleared", 64'(trig_err), 64'd0);
        check(pkt_done == 1'b1, "R8 done kept by err clear", 64'(pkt_done), 64'd1);
        reg_write(3'd4, 64'd1);
        #1;
        check(pkt_done == 1'b0, "R8 done cleared by write", 64'(pkt_done), 64'd0);

        // R10: route write while busy is ignored, now and for the next packet
        run_pkt(64'h0000_00AA_0000_0055, 6, 2'd0, 2'd1, 8'h32, 2);
        run_pkt(64'h0000_00AA_0000_0055, 6, 2'd0, 2'd0, 8'h33, 0);
        check(trig_err == 1'b0, "R10 no error from config write", 64'(trig_err), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule